// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a per-context root entry and then up to three levels of page tables from physical memory. The read port is word wide and carries one request at a time. A request is accepted only while the walker is idle. The walker then fetches entries until it meets a leaf, a bad entry, or the end of the third level. It reports the result with a done strobe that lasts one cycle.

On success the block returns the physical address and the leaf entry. A leaf met at the first or second table level maps a large region, so more of the virtual address passes through as offset. On failure it returns a compact error code that holds the level where the walk stopped and the kind of fault. Before it reports success, the walker makes sure the leaf carries its referenced mark, and its modified mark on a write. When it has to set a mark, it writes the updated entry back to the address it was read from.

With translation turned off, the virtual address is passed through with no memory traffic. Permission decoding and any caching of translations belong to the blocks around it.

Top module: `pgwalk_top`

## Requirements
- R1: With `cfg_enable` low when a request is accepted, the walk completes with `resp_bypass`=1, `resp_err`=0, `resp_paddr` equal to the zero-extended virtual address, and no memory read or write.
- R2: With `cfg_enable` high, the first read goes to address (`cfg_ctx_ptr` << 4) + (`cfg_ctx_num` << 2), on 36 bits.
- R3: Entry bits [1:0] give its kind: 0 invalid, 1 table pointer, 2 leaf, 3 reserved. After a table pointer read at step L (0 for the root entry), the next read is at ((entry with bits [1:0] cleared) << 4) + 4 × index. The index is virtual-address bits [31:24] for step 1, [23:18] for step 2 and [17:12] for step 3.
- R4: An invalid entry at step L ends the walk with `resp_err`=1 and `resp_code` = (L << 8) | 0x04.
- R5: A reserved entry at any step, a leaf at step 0, or a table pointer at step 3 ends the walk with `resp_err`=1 and `resp_code` = (L << 8) | 0x10.
- R6: For a leaf at step L, `resp_paddr` = ((entry & 0xFFFFFF00) << 4) + offset. The offset is virtual-address bits [23:0] for L=1, [17:0] for L=2 and [11:0] for L=3.
- R7: The leaf is written back to the address it was read from when its referenced bit (bit 5) is clear, or when the access is a write and its modified bit (bit 6) is clear. The value written has bit 5 set, and bit 6 set on a write. Otherwise no write is made.
- R8: Memory requests are one at a time. `mem_rd_req` and `mem_wr_req` are never high together. A request holds its address and kind until a cycle with `mem_valid` high.
- R9: `req_ready` is high only while idle. `done` is high for exactly one cycle per accepted request. Requests raised while busy are ignored.
- R10: On success `resp_err`=0 and `resp_entry` is the leaf as finally held in memory, including any marks set under R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| cfg_enable | input | 1 | Translation on |
| cfg_ctx_ptr | input | 32 | Root table pointer |
| cfg_ctx_num | input | CTX_W | Context number |
| mem_rd_req | output | 1 | Memory read request |
| mem_wr_req | output | 1 | Memory write request |
| mem_addr | output | 36 | Memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data |
| mem_valid | input | 1 | Memory completes current request |
| done | output | 1 | Result valid, one cycle |
| resp_err | output | 1 | Walk failed |
| resp_code | output | 10 | Fault code: step in [9:8], cause in [7:0] |
| resp_bypass | output | 1 | Result came from pass-through |
| resp_paddr | output | 36 | Physical address |
| resp_entry | output | 32 | Final leaf entry |

## Verification
Directed walks use tables built to stop at every step with every entry kind. They separate the root-leaf and third-step-pointer faults from the plain reserved fault, and they check that the step number in the code is right. Leaves at each of the three levels, with each referenced and modified combination under reads and writes, show whether the offset width follows the level and whether the write-back fires only when a mark is missing. Random table chains with random pointers, contexts and addresses cover the indexing arithmetic and the carries in the address sums. Memory latency is random, and a run with requests raised during a busy walk shows that extra requests are ignored.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   localparam int VA_W   = 32;
   localparam int WORD_W = 32;
   localparam int PA_W   = WORD_W + 4;
   localparam int ERR_W  = 10;

   localparam int REF_BIT = 5;
   localparam int MOD_BIT = 6;

   localparam logic [7:0] CAUSE_INVALID = 8'h04;
   localparam logic [7:0] CAUSE_BADTYPE = 8'h10;

   typedef enum logic [1:0] {
      ET_INVALID = 2'd0,
      ET_TABLE   = 2'd1,
      ET_LEAF    = 2'd2,
      ET_RESV    = 2'd3
   } ent_type_e;

   typedef enum logic [1:0] {
      WK_DESCEND = 2'd0,
      WK_LEAF    = 2'd1,
      WK_FAULT   = 2'd2
   } walk_kind_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_FETCH = 2'd1,
      S_WBACK = 2'd2,
      S_DONE  = 2'd3
   } walk_state_e;

   function automatic int idx_lsb(input int step);
      case (step)
         1:       return 24;
         2:       return 18;
         default: return 12;
      endcase
   endfunction

   function automatic int idx_bits(input int step);
      return (step == 1) ? 8 : 6;
   endfunction
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
   import pgwalk_pkg::*;
#(
   parameter int CTX_W = 8
) (
   input  logic [WORD_W-1:0] ctx_ptr,
   input  logic [CTX_W-1:0]  ctx_num,
   input  logic [19:0]       va_hi,
   input  logic [WORD_W-1:0] desc,
   input  logic [1:0]        next_step,
   output logic [PA_W-1:0]   ctx_addr,
   output logic [PA_W-1:0]   tbl_addr
);
   localparam int PAGE_SH = 12;

   logic [PA_W-1:0] idx_off [4];
   logic            unused_desc;

   assign idx_off[0] = '0;

   for (genvar g = 1; g < 4; g++) begin : g_idx
      localparam int LSB = idx_lsb(g) - PAGE_SH;
      localparam int NB  = idx_bits(g);
      assign idx_off[g] = PA_W'(va_hi[LSB +: NB]) << 2;
   end

   assign ctx_addr    = {ctx_ptr, 4'h0} + (PA_W'(ctx_num) << 2);
   assign tbl_addr    = {desc[WORD_W-1:2], 6'b0} + idx_off[next_step];
   assign unused_desc = ^desc[1:0];
endmodule

// File: rtl/pgwalk_entry.sv
module pgwalk_entry
   import pgwalk_pkg::*;
#(
   parameter bit KEEP_L3_OFFSET = 1'b1
) (
   input  logic [WORD_W-1:0] entry,
   input  logic [1:0]        step,
   input  logic              is_write,
   input  logic [23:0]       va_lo,
   output walk_kind_e        kind,
   output logic [ERR_W-1:0]  err_code,
   output logic              need_wb,
   output logic [WORD_W-1:0] upd_entry,
   output logic [PA_W-1:0]   leaf_paddr
);
   logic [PA_W-1:0] off_l3;
   logic [PA_W-1:0] off;
   logic            unused_bits;

   if (KEEP_L3_OFFSET) begin : g_l3_keep
      assign off_l3 = PA_W'(va_lo[11:0]);
   end else begin : g_l3_align
      assign off_l3 = '0;
   end

   always_comb begin
      kind     = WK_FAULT;
      err_code = {step, CAUSE_BADTYPE};
      case (ent_type_e'(entry[1:0]))
         ET_INVALID: err_code = {step, CAUSE_INVALID};
         ET_TABLE:   if (step != 2'd3) kind = WK_DESCEND;
         ET_LEAF:    if (step != 2'd0) kind = WK_LEAF;
         default:    kind = WK_FAULT;
      endcase
   end

   always_comb begin
      case (step)
         2'd1:    off = PA_W'(va_lo[23:0]);
         2'd2:    off = PA_W'(va_lo[17:0]);
         default: off = off_l3;
      endcase
   end

   assign leaf_paddr  = {entry[WORD_W-1:8], 12'h000} + off;
   assign need_wb     = !entry[REF_BIT] || (is_write && !entry[MOD_BIT]);
   assign upd_entry   = entry | (WORD_W'(1) << REF_BIT)
                              | (WORD_W'(is_write) << MOD_BIT);
   assign unused_bits = ^{entry[7], entry[4:2]};
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int CTX_W          = 8,
   parameter bit KEEP_L3_OFFSET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic              req_write,
   input  logic              cfg_enable,
   input  logic [WORD_W-1:0] cfg_ctx_ptr,
   input  logic [CTX_W-1:0]  cfg_ctx_num,
   output logic              mem_rd_req,
   output logic              mem_wr_req,
   output logic [PA_W-1:0]   mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_valid,
   output logic              done,
   output logic              resp_err,
   output logic [ERR_W-1:0]  resp_code,
   output logic              resp_bypass,
   output logic [PA_W-1:0]   resp_paddr,
   output logic [WORD_W-1:0] resp_entry
);
   if (CTX_W < 1 || CTX_W > 28) begin : g_bad_ctx_w
      $error("pgwalk_top: CTX_W must be in 1..28");
   end

   walk_state_e       state_q;
   logic [1:0]        step_q;
   logic [1:0]        nxt_step;
   logic [PA_W-1:0]   addr_q;
   logic [VA_W-1:0]   va_q;
   logic              wr_q;
   logic              err_q, byp_q;
   logic [ERR_W-1:0]  code_q;
   logic [PA_W-1:0]   pa_q;
   logic [WORD_W-1:0] ent_q;

   logic [PA_W-1:0]   ctx_addr, tbl_addr, leaf_paddr;
   walk_kind_e        kind;
   logic [ERR_W-1:0]  err_code;
   logic              need_wb;
   logic [WORD_W-1:0] upd_entry;

   assign nxt_step = step_q + 2'd1;

   pgwalk_addr #(.CTX_W(CTX_W)) u_addr (
      .ctx_ptr   (cfg_ctx_ptr),
      .ctx_num   (cfg_ctx_num),
      .va_hi     (va_q[31:12]),
      .desc      (mem_rdata),
      .next_step (nxt_step),
      .ctx_addr  (ctx_addr),
      .tbl_addr  (tbl_addr)
   );

   pgwalk_entry #(.KEEP_L3_OFFSET(KEEP_L3_OFFSET)) u_entry (
      .entry      (mem_rdata),
      .step       (step_q),
      .is_write   (wr_q),
      .va_lo      (va_q[23:0]),
      .kind       (kind),
      .err_code   (err_code),
      .need_wb    (need_wb),
      .upd_entry  (upd_entry),
      .leaf_paddr (leaf_paddr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         step_q  <= '0;
         addr_q  <= '0;
         va_q    <= '0;
         wr_q    <= 1'b0;
         err_q   <= 1'b0;
         byp_q   <= 1'b0;
         code_q  <= '0;
         pa_q    <= '0;
         ent_q   <= '0;
      end else begin
         case (state_q)
            S_IDLE: if (req_valid) begin
               va_q   <= req_vaddr;
               wr_q   <= req_write;
               step_q <= '0;
               err_q  <= 1'b0;
               code_q <= '0;
               ent_q  <= '0;
               if (!cfg_enable) begin
                  byp_q   <= 1'b1;
                  pa_q    <= PA_W'(req_vaddr);
                  state_q <= S_DONE;
               end else begin
                  byp_q   <= 1'b0;
                  pa_q    <= '0;
                  addr_q  <= ctx_addr;
                  state_q <= S_FETCH;
               end
            end
            S_FETCH: if (mem_valid) begin
               case (kind)
                  WK_DESCEND: begin
                     addr_q <= tbl_addr;
                     step_q <= nxt_step;
                  end
                  WK_LEAF: begin
                     pa_q    <= leaf_paddr;
                     ent_q   <= upd_entry;
                     state_q <= need_wb ? S_WBACK : S_DONE;
                  end
                  default: begin
                     err_q   <= 1'b1;
                     code_q  <= err_code;
                     state_q <= S_DONE;
                  end
               endcase
            end
            S_WBACK: if (mem_valid) state_q <= S_DONE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == S_IDLE);
   assign done        = (state_q == S_DONE);
   assign mem_rd_req  = (state_q == S_FETCH);
   assign mem_wr_req  = (state_q == S_WBACK);
   assign mem_addr    = addr_q;
   assign mem_wdata   = ent_q;
   assign resp_err    = err_q;
   assign resp_code   = code_q;
   assign resp_bypass = byp_q;
   assign resp_paddr  = pa_q;
   assign resp_entry  = ent_q;

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_take_then_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));
   p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd_req || mem_wr_req) && !mem_valid) |=>
         ($stable(mem_addr) && $stable(mem_rd_req) && $stable(mem_wr_req)));
   p_wb_marks_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> mem_wdata[REF_BIT]);
   p_code_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && resp_err) |->
         (resp_code[7:0] == CAUSE_INVALID || resp_code[7:0] == CAUSE_BADTYPE));
   p_bypass_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && resp_bypass) |-> $past(req_valid && req_ready));
endmodule

// File: tb/pgwalk_top_tb.sv
`timescale 1ns/1ps
module pgwalk_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, cfg_enable = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0, cfg_ctx_ptr = '0;
   logic [7:0]  cfg_ctx_num = '0;
   logic        mem_rd_req, mem_wr_req;
   logic [35:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_valid = 1'b0;
   logic        done, resp_err, resp_bypass;
   logic [9:0]  resp_code;
   logic [35:0] resp_paddr;
   logic [31:0] resp_entry;

   int n_cmp = 0, n_bad = 0;
   int n_reads = 0, n_writes = 0, wait_cnt = 0;
   logic [35:0] first_rd, wb_addr;
   logic [31:0] wb_data;
   logic [31:0] mem [logic [35:0]];

   always #4 clk = ~clk;

   pgwalk_top u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_write(req_write), .cfg_enable(cfg_enable),
      .cfg_ctx_ptr(cfg_ctx_ptr), .cfg_ctx_num(cfg_ctx_num),
      .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
      .done(done), .resp_err(resp_err), .resp_code(resp_code),
      .resp_bypass(resp_bypass), .resp_paddr(resp_paddr), .resp_entry(resp_entry)
   );

   function automatic logic [31:0] rdm(input logic [35:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [35:0] caddr(input logic [31:0] p, input logic [7:0] c);
      return ({4'h0, p} << 4) + ({28'h0, c} << 2);
   endfunction

   function automatic logic [35:0] taddr(input logic [31:0] e, input logic [31:0] va, input int s);
      logic [35:0] ix;
      case (s)
         1:       ix = {28'h0, va[31:24]};
         2:       ix = {30'h0, va[23:18]};
         default: ix = {30'h0, va[17:12]};
      endcase
      return ({4'h0, e & ~32'h3} << 4) + ix * 4;
   endfunction

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   // memory model: random latency, answers one request at a time
   initial forever begin
      @(negedge clk);
      if (mem_valid) mem_valid = 1'b0;
      else if (rst_n && (mem_rd_req || mem_wr_req)) begin
         if (wait_cnt == 0) begin
            mem_valid = 1'b1;
            if (mem_rd_req) begin
               if (n_reads == 0) first_rd = mem_addr;
               mem_rdata = rdm(mem_addr);
               n_reads++;
            end else begin
               mem[mem_addr] = mem_wdata;
               wb_addr = mem_addr;
               wb_data = mem_wdata;
               n_writes++;
            end
            wait_cnt = $urandom % 3;
         end else wait_cnt--;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog expired");
      summary();
      $finish;
   end

   task automatic ref_walk(input logic [31:0] va, input bit wr, input bit en,
                           input logic [31:0] p, input logic [7:0] c,
                           output bit err, output logic [9:0] code,
                           output logic [35:0] pa, output logic [31:0] ent,
                           output int reads, output bit wb);
      logic [35:0] a;
      logic [31:0] e;
      logic [35:0] off;
      err = 0; code = 0; pa = 0; ent = 0; reads = 0; wb = 0;
      if (!en) begin pa = {4'h0, va}; return; end
      a = caddr(p, c);
      for (int s = 0; s < 4; s++) begin
         e = rdm(a);
         reads++;
         if (e[1:0] == 2'd0) begin err = 1; code = 10'(s * 256 + 4); return; end
         if (e[1:0] == 2'd3 || (e[1:0] == 2'd1 && s == 3) || (e[1:0] == 2'd2 && s == 0)) begin
            err = 1; code = 10'(s * 256 + 16); return;
         end
         if (e[1:0] == 2'd1) a = taddr(e, va, s + 1);
         else begin
            off = (s == 1) ? {12'h0, va[23:0]} : (s == 2) ? {18'h0, va[17:0]} : {24'h0, va[11:0]};
            pa  = ({4'h0, e & 32'hFFFFFF00} << 4) + off;
            ent = e | 32'h20 | (wr ? 32'h40 : 32'h0);
            wb  = !e[5] || (wr && !e[6]);
            return;
         end
      end
   endtask

   function automatic logic [3:0] pick(input int s);
      int r = $urandom % 100;
      if (s == 0) return (r < 85) ? 4'd1 : (r < 92) ? 4'd0 : (r < 96) ? 4'd3 : 4'd2;
      if (s == 3) return (r < 80) ? 4'd2 : (r < 88) ? 4'd1 : (r < 94) ? 4'd0 : 4'd3;
      return (r < 55) ? 4'd1 : (r < 85) ? 4'd2 : (r < 93) ? 4'd0 : 4'd3;
   endfunction

   // ft holds a forced kind per step in 4-bit fields, 4'hF = random
   task automatic build_chain(input logic [31:0] va, input logic [31:0] p, input logic [7:0] c,
                              input logic [15:0] ft, input int flags);
      logic [35:0] a = caddr(p, c);
      logic [31:0] e, r;
      logic [3:0]  t;
      mem.delete();
      for (int s = 0; s < 4; s++) begin
         t = ft[4*s +: 4];
         if (t == 4'hF) t = pick(s);
         r = $urandom;
         case (t)
            4'd0:    e = r & ~32'h3;
            4'd1:    e = (r & ~32'h3) | 32'h1;
            4'd2: begin
               e = (r & ~32'h3) | 32'h2;
               if (flags >= 0) e = (e & ~32'h60) | (32'(flags) << 5);
            end
            default: e = r | 32'h3;
         endcase
         mem[a] = e;
         if (t != 4'd1 || s == 3) break;
         a = taddr(e, va, s + 1);
      end
   endtask

   task automatic run_walk(input string tag, input logic [31:0] va, input bit wr, input bit en,
                           input logic [31:0] p, input logic [7:0] c, input bit poke);
      bit e_err, e_wb, busy_ok;
      logic [9:0]  e_code;
      logic [35:0] e_pa;
      logic [31:0] e_ent;
      int e_reads, lim;
      ref_walk(va, wr, en, p, c, e_err, e_code, e_pa, e_ent, e_reads, e_wb);
      @(negedge clk);
      req_valid = 1; req_vaddr = va; req_write = wr;
      cfg_enable = en; cfg_ctx_ptr = p; cfg_ctx_num = c;
      n_reads = 0; n_writes = 0;
      @(negedge clk);
      if (poke) begin req_vaddr = va ^ 32'hFFFFF000; req_write = !wr; end
      else req_valid = 0;
      busy_ok = 1; lim = 0;
      while (!done && lim < 400) begin
         if (req_ready) busy_ok = 0;
         @(negedge clk);
         lim++;
      end
      req_valid = 0;
      chk(done == 1'b1, "R9", {tag, " done seen"}, 64'(done), 64'd1);
      if (poke) chk(busy_ok, "R9", {tag, " ready low while busy"}, 64'(busy_ok), 64'd1);
      chk(resp_err == e_err, e_err ? "R4" : "R10", {tag, " err flag"}, 64'(resp_err), 64'(e_err));
      chk(resp_bypass == !en, "R1", {tag, " bypass flag"}, 64'(resp_bypass), 64'(!en));
      chk(n_reads == e_reads, en ? "R3" : "R1", {tag, " read count"}, 64'(n_reads), 64'(e_reads));
      if (en) chk(first_rd == caddr(p, c), "R2", {tag, " first address"}, 64'(first_rd), 64'(caddr(p, c)));
      if (e_err) chk(resp_code == e_code, e_code[4] ? "R5" : "R4", {tag, " code"}, 64'(resp_code), 64'(e_code));
      else begin
         chk(resp_paddr == e_pa, en ? "R6" : "R1", {tag, " paddr"}, 64'(resp_paddr), 64'(e_pa));
         if (en) chk(resp_entry == e_ent, "R10", {tag, " entry"}, 64'(resp_entry), 64'(e_ent));
      end
      chk(n_writes == int'(e_wb), "R7", {tag, " write count"}, 64'(n_writes), 64'(e_wb));
      if (e_wb) chk(wb_data == e_ent, "R7", {tag, " written value"}, 64'(wb_data), 64'(e_ent));
      @(negedge clk);
      chk(done == 1'b0, "R9", {tag, " done one cycle"}, 64'(done), 64'd0);
      if (poke) begin
         repeat (3) @(negedge clk);
         chk(!done && req_ready && n_reads == e_reads, "R9", {tag, " busy request dropped"},
             64'(n_reads), 64'(e_reads));
      end
   endtask

   initial begin
      logic [31:0] va;
      logic [31:0] p;
      int unsigned seed_val;
      seed_val = $urandom(32'd2024);
      va = 32'h12A5_C7E9;
      p  = 32'h0003_4000;
      repeat (3) @(negedge clk);
      chk(req_ready && !done && !mem_rd_req && !mem_wr_req, "R9", "reset quiet",
          64'({req_ready, done, mem_rd_req, mem_wr_req}), 64'h8);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "ready after reset", 64'(req_ready), 64'd1);

      mem.delete();
      run_walk("R1 bypass", 32'hDEAD_BEEF, 1, 0, p, 8'h11, 0);
      build_chain(va, p, 8'h07, 16'hFFF0, -1);
      run_walk("R4 root invalid", va, 0, 1, p, 8'h07, 0);
      build_chain(va, p, 8'h07, 16'hFFF2, -1);
      run_walk("R5 root leaf", va, 0, 1, p, 8'h07, 0);
      build_chain(va, p, 8'hFF, 16'h1111, -1);
      run_walk("R5 step3 pointer", va, 1, 1, p, 8'hFF, 0);
      build_chain(va, p, 8'h01, 16'hFF01, -1);
      run_walk("R4 step1 invalid", va, 0, 1, p, 8'h01, 0);
      build_chain(va, p, 8'h02, 16'hF311, -1);
      run_walk("R5 step2 reserved", va, 0, 1, p, 8'h02, 0);
      build_chain(va, p, 8'h03, 16'hFF21, 3);
      run_walk("R6 step1 leaf marked write", va, 1, 1, p, 8'h03, 0);
      build_chain(va, p, 8'h04, 16'hF211, 0);
      run_walk("R7 step2 leaf unmarked read", va, 0, 1, p, 8'h04, 0);
      build_chain(va, p, 8'h05, 16'h2111, 1);
      run_walk("R7 step3 leaf clean write", va, 1, 1, p, 8'h05, 0);
      build_chain(va, p, 8'h06, 16'h2111, 3);
      run_walk("R6 step3 leaf marked read", va, 0, 1, p, 8'h06, 0);
      build_chain(va, p, 8'h08, 16'h2111, 0);
      run_walk("R9 busy poke", va, 1, 1, p, 8'h08, 1);

      for (int i = 0; i < 300; i++) begin
         logic [31:0] rva = $urandom;
         logic [31:0] rp  = $urandom;
         logic [7:0]  rc  = 8'($urandom);
         bit          ren = ($urandom % 10) != 0;
         build_chain(rva, rp, rc, 16'hFFFF, -1);
         run_walk("R3 random", rva, 1'($urandom), ren, rp, rc, (i % 50) == 7);
      end

      summary();
      $finish;
   end
endmodule